// File: doc/BRIEF.md
# PHY Reset and Strap Latch Controller

This block sequences the two kinds of reset that a PHY management register set sees. While the chip-level hardware reset is held, it samples three configuration strap inputs each cycle: auto-negotiation enable, speed select and duplex. The values present on the last clock before reset is released are kept in a shadow store until the next hardware reset. The same values are loaded into the live control fields. After release, the register port stays dark for a parameterised blackout window. During that window reads return zero and writes are dropped.

Software can start a reset of its own by writing the reset bit of the control register. This reset does not look at the strap pins again. It copies the shadow values back into the control fields and clears power-down. It then holds the reset bit at one for a fixed number of cycles, so that software can poll it until it clears. Reads stay available throughout. Writes are dropped until the bit clears.

State machine: `ST_HOLD` (hardware reset held) → `ST_BLACKOUT` (on the first cycle with reset released) → `ST_RUN` (when the blackout count expires) → `ST_SWRST` (on a control write with the reset bit set) → `ST_RUN` (when the software-reset count expires). A low hardware reset sends every state back to `ST_HOLD`.

Top module: `phy_rst_strap_ctl`

## Requirements
- R1: While `hw_rst_n` is low, the shadow store and the live fields (`aneg_en_o`, `speed_sel_o`, `duplex_full_o`) take the strap inputs on every clock. `pwr_down_o` is 0. On release, the values sampled on the last low clock are kept.
- R2: Strap input changes made after the release, including a change in the same cycle as the release, alter neither the shadow store nor the live fields.
- R3: `regs_ready_o` is low in reset. It rises after the (BLACKOUT_CYC+1)-th rising edge at which `hw_rst_n` is high.
- R4: While `regs_ready_o` is low, a read returns 0 and a write changes nothing.
- R5: Register map. Address 0 is the control register, with bit 15 = reset, bit 13 = speed, bit 12 = auto-negotiation, bit 11 = power-down, bit 8 = duplex, and all other bits 0. Address 1 is the strap readback, with bit 0 = auto-negotiation, bit 1 = speed, bit 2 = duplex. Any other address reads 0. Read data is registered and appears after the edge that sampled `reg_rd_en_i`.
- R6: In normal operation, a write to address 0 with bit 15 clear updates the four control fields from the written bits.
- R7: A write to address 0 with bit 15 set starts a software reset. The fields are restored from the shadow store, power-down is cleared, and the other bits of that write are ignored. `sw_rst_busy_o` and read bit 15 are 1 for exactly SWRST_CYC cycles and then clear.
- R8: During a software reset, reads return the current register contents and every write is ignored.
- R9: A software reset does not re-sample the strap pins. Pin values changed after the last hardware reset are not restored.
- R10: A hardware reset during a software reset aborts it. On the next cycle `sw_rst_busy_o` and `regs_ready_o` are both low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| hw_rst_n | input | 1 | Synchronous active-low hardware reset |
| strap_aneg_i | input | 1 | Auto-negotiation enable strap |
| strap_speed_i | input | 1 | Speed select strap |
| strap_duplex_i | input | 1 | Full-duplex strap |
| reg_wr_en_i | input | 1 | Register write strobe |
| reg_rd_en_i | input | 1 | Register read strobe |
| reg_addr_i | input | ADDR_W | Register address |
| reg_wdata_i | input | 16 | Write data |
| reg_rdata_o | output | 16 | Registered read data |
| regs_ready_o | output | 1 | Register port available |
| sw_rst_busy_o | output | 1 | Software reset in progress |
| aneg_en_o | output | 1 | Live auto-negotiation enable |
| speed_sel_o | output | 1 | Live speed select |
| duplex_full_o | output | 1 | Live duplex |
| pwr_down_o | output | 1 | Live power-down control |

## Verification
The bench changes the strap pins in the very cycle that reset is released. A latch that samples one clock late would report the inverted values. It also changes the straps before a software reset. A design that re-reads the pins would restore the new values instead of the latched ones. Read and write strobes are held through the whole blackout. An off-by-one in the window length, or a leak of the live fields into the read data, shows up as a wrong cycle count or nonzero data. During a software reset the bench writes with other bits set, counts the busy cycles, and then asserts hardware reset mid-sequence. A late self-clear, an accepted write, or a failure to abort would each give wrong read-back or outputs.

// File: rtl/phy_rst_pkg.sv
package phy_rst_pkg;

    typedef enum logic [1:0] {
        ST_HOLD,
        ST_BLACKOUT,
        ST_RUN,
        ST_SWRST
    } prs_state_e;

    typedef struct packed {
        logic aneg;
        logic speed;
        logic duplex;
    } strap_t;

    localparam int unsigned DATA_W       = 16;
    localparam int unsigned CTL_RST_BIT  = 15;
    localparam int unsigned CTL_SPD_BIT  = 13;
    localparam int unsigned CTL_ANEG_BIT = 12;
    localparam int unsigned CTL_PDN_BIT  = 11;
    localparam int unsigned CTL_DPX_BIT  = 8;

    localparam int unsigned ADDR_CTL   = 0;
    localparam int unsigned ADDR_STRAP = 1;

endpackage

// File: rtl/prs_seq_fsm.sv
module prs_seq_fsm
    import phy_rst_pkg::*;
#(
    parameter int unsigned BLACKOUT_CYC = 250000,
    parameter int unsigned SWRST_CYC    = 64
) (
    input  logic       clk,
    input  logic       hw_rst_n,
    input  logic       wr_en,
    input  logic       wr_is_ctl,
    input  logic       wr_rst_bit,
    output prs_state_e state,
    output logic       wr_accept,
    output logic       swrst_start,
    output logic       ready,
    output logic       busy
);

    localparam int unsigned MAX_CYC = (BLACKOUT_CYC > SWRST_CYC) ? BLACKOUT_CYC : SWRST_CYC;
    localparam int unsigned CNT_W   = $clog2(MAX_CYC + 1);
    localparam logic [CNT_W-1:0] BLK_LAST = CNT_W'(BLACKOUT_CYC - 1);
    localparam logic [CNT_W-1:0] SWR_LAST = CNT_W'(SWRST_CYC - 1);

    prs_state_e       state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic             ctl_wr;

    assign ctl_wr = wr_en && wr_is_ctl;

    // next-state and counter
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            ST_HOLD: begin
                state_d = ST_BLACKOUT;
                cnt_d   = '0;
            end
            ST_BLACKOUT: begin
                if (cnt_q == BLK_LAST) begin
                    state_d = ST_RUN;
                    cnt_d   = '0;
                end else begin
                    cnt_d = cnt_q + 1'b1;
                end
            end
            ST_RUN: begin
                if (ctl_wr && wr_rst_bit) begin
                    state_d = ST_SWRST;
                    cnt_d   = '0;
                end
            end
            ST_SWRST: begin
                if (cnt_q == SWR_LAST) begin
                    state_d = ST_RUN;
                    cnt_d   = '0;
                end else begin
                    cnt_d = cnt_q + 1'b1;
                end
            end
            default: begin
                state_d = ST_HOLD;
                cnt_d   = '0;
            end
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!hw_rst_n) begin
            state_q <= ST_HOLD;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // outputs
    always_comb begin
        wr_accept   = 1'b0;
        swrst_start = 1'b0;
        ready       = 1'b0;
        busy        = 1'b0;
        unique case (state_q)
            ST_HOLD, ST_BLACKOUT: begin
                ready = 1'b0;
            end
            ST_RUN: begin
                ready       = 1'b1;
                wr_accept   = ctl_wr && !wr_rst_bit;
                swrst_start = ctl_wr && wr_rst_bit;
            end
            ST_SWRST: begin
                ready = 1'b1;
                busy  = 1'b1;
            end
            default: begin
                ready = 1'b0;
            end
        endcase
    end

    assign state = state_q;

endmodule

// File: rtl/prs_strap_latch.sv
module prs_strap_latch
    import phy_rst_pkg::*;
(
    input  logic   clk,
    input  logic   hw_rst_n,
    input  strap_t straps,
    output strap_t shadow
);

    strap_t shadow_q;

    // tracks the pins only while reset is held; the last low cycle wins
    always_ff @(posedge clk) begin
        if (!hw_rst_n) begin
            shadow_q <= straps;
        end
    end

    assign shadow = shadow_q;

endmodule

// File: rtl/prs_ctrl_regs.sv
module prs_ctrl_regs
    import phy_rst_pkg::*;
#(
    parameter int unsigned ADDR_W = 5
) (
    input  logic              clk,
    input  logic              hw_rst_n,
    input  strap_t            straps,
    input  strap_t            shadow,
    input  logic              wr_accept,
    input  logic              swrst_start,
    input  logic              ready,
    input  logic              busy,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output strap_t            live,
    output logic              pdn
);

    strap_t            live_q;
    logic              pdn_q;
    logic [DATA_W-1:0] rd_mux;
    logic [DATA_W-1:0] rdata_q;

    always_ff @(posedge clk) begin
        if (!hw_rst_n) begin
            live_q <= straps;
            pdn_q  <= 1'b0;
        end else if (swrst_start) begin
            live_q <= shadow;
            pdn_q  <= 1'b0;
        end else if (wr_accept) begin
            live_q.aneg   <= wdata[CTL_ANEG_BIT];
            live_q.speed  <= wdata[CTL_SPD_BIT];
            live_q.duplex <= wdata[CTL_DPX_BIT];
            pdn_q         <= wdata[CTL_PDN_BIT];
        end
    end

    always_comb begin
        rd_mux = '0;
        if (addr == ADDR_W'(ADDR_CTL)) begin
            rd_mux[CTL_RST_BIT]  = busy;
            rd_mux[CTL_SPD_BIT]  = live_q.speed;
            rd_mux[CTL_ANEG_BIT] = live_q.aneg;
            rd_mux[CTL_PDN_BIT]  = pdn_q;
            rd_mux[CTL_DPX_BIT]  = live_q.duplex;
        end else if (addr == ADDR_W'(ADDR_STRAP)) begin
            rd_mux[0] = shadow.aneg;
            rd_mux[1] = shadow.speed;
            rd_mux[2] = shadow.duplex;
        end
    end

    always_ff @(posedge clk) begin
        if (!hw_rst_n) begin
            rdata_q <= '0;
        end else if (rd_en) begin
            rdata_q <= ready ? rd_mux : '0;
        end
    end

    assign rdata = rdata_q;
    assign live  = live_q;
    assign pdn   = pdn_q;

endmodule

// File: rtl/phy_rst_strap_ctl.sv
module phy_rst_strap_ctl
    import phy_rst_pkg::*;
#(
    parameter int unsigned ADDR_W       = 5,
    parameter int unsigned BLACKOUT_CYC = 250000,
    parameter int unsigned SWRST_CYC    = 64
) (
    input  logic              clk,
    input  logic              hw_rst_n,
    input  logic              strap_aneg_i,
    input  logic              strap_speed_i,
    input  logic              strap_duplex_i,
    input  logic              reg_wr_en_i,
    input  logic              reg_rd_en_i,
    input  logic [ADDR_W-1:0] reg_addr_i,
    input  logic [15:0]       reg_wdata_i,
    output logic [15:0]       reg_rdata_o,
    output logic              regs_ready_o,
    output logic              sw_rst_busy_o,
    output logic              aneg_en_o,
    output logic              speed_sel_o,
    output logic              duplex_full_o,
    output logic              pwr_down_o
);

    prs_state_e state;
    strap_t     pins;
    strap_t     shadow;
    strap_t     live;
    logic       wr_accept;
    logic       swrst_start;
    logic       ready;
    logic       busy;
    logic       pdn;

    assign pins.aneg   = strap_aneg_i;
    assign pins.speed  = strap_speed_i;
    assign pins.duplex = strap_duplex_i;

    prs_seq_fsm #(
        .BLACKOUT_CYC (BLACKOUT_CYC),
        .SWRST_CYC    (SWRST_CYC)
    ) u_fsm (
        .clk         (clk),
        .hw_rst_n    (hw_rst_n),
        .wr_en       (reg_wr_en_i),
        .wr_is_ctl   (reg_addr_i == ADDR_W'(ADDR_CTL)),
        .wr_rst_bit  (reg_wdata_i[CTL_RST_BIT]),
        .state       (state),
        .wr_accept   (wr_accept),
        .swrst_start (swrst_start),
        .ready       (ready),
        .busy        (busy)
    );

    prs_strap_latch u_latch (
        .clk      (clk),
        .hw_rst_n (hw_rst_n),
        .straps   (pins),
        .shadow   (shadow)
    );

    prs_ctrl_regs #(
        .ADDR_W (ADDR_W)
    ) u_regs (
        .clk         (clk),
        .hw_rst_n    (hw_rst_n),
        .straps      (pins),
        .shadow      (shadow),
        .wr_accept   (wr_accept),
        .swrst_start (swrst_start),
        .ready       (ready),
        .busy        (busy),
        .rd_en       (reg_rd_en_i),
        .addr        (reg_addr_i),
        .wdata       (reg_wdata_i),
        .rdata       (reg_rdata_o),
        .live        (live),
        .pdn         (pdn)
    );

    assign regs_ready_o  = ready;
    assign sw_rst_busy_o = busy;
    assign aneg_en_o     = live.aneg;
    assign speed_sel_o   = live.speed;
    assign duplex_full_o = live.duplex;
    assign pwr_down_o    = pdn;

endmodule

// File: rtl/prs_sva.sv
module prs_sva
    import phy_rst_pkg::*;
#(
    parameter int unsigned ADDR_W = 5
) (
    input logic              clk,
    input logic              hw_rst_n,
    input logic              reg_rd_en_i,
    input logic [ADDR_W-1:0] reg_addr_i,
    input logic [15:0]       reg_rdata_o,
    input logic              regs_ready_o,
    input logic              sw_rst_busy_o,
    input logic              aneg_en_o,
    input logic              speed_sel_o,
    input logic              duplex_full_o,
    input logic              pwr_down_o,
    input strap_t            shadow
);

    logic [3:0] fields;
    assign fields = {aneg_en_o, speed_sel_o, duplex_full_o, pwr_down_o};

    a_r4_dark_read_zero: assert property (@(posedge clk) disable iff (!hw_rst_n)
        (!regs_ready_o && reg_rd_en_i) |=> (reg_rdata_o == 16'h0000));

    a_r4_dark_fields_stable: assert property (@(posedge clk) disable iff (!hw_rst_n)
        !regs_ready_o |=> $stable(fields));

    a_r2_shadow_held: assert property (@(posedge clk) disable iff (!hw_rst_n)
        $past(hw_rst_n) |-> $stable(shadow));

    a_r7_restore_from_shadow: assert property (@(posedge clk) disable iff (!hw_rst_n)
        $rose(sw_rst_busy_o) |-> ({aneg_en_o, speed_sel_o, duplex_full_o} == shadow && !pwr_down_o));

    a_r8_busy_fields_stable: assert property (@(posedge clk) disable iff (!hw_rst_n)
        sw_rst_busy_o |=> $stable(fields));

    a_r7_busy_bit_read: assert property (@(posedge clk) disable iff (!hw_rst_n)
        (sw_rst_busy_o && reg_rd_en_i && reg_addr_i == ADDR_W'(ADDR_CTL)) |=> reg_rdata_o[CTL_RST_BIT]);

    a_r3_busy_implies_ready: assert property (@(posedge clk) disable iff (!hw_rst_n)
        sw_rst_busy_o |-> regs_ready_o);

endmodule

bind phy_rst_strap_ctl prs_sva #(.ADDR_W(ADDR_W)) u_sva (
    .clk           (clk),
    .hw_rst_n      (hw_rst_n),
    .reg_rd_en_i   (reg_rd_en_i),
    .reg_addr_i    (reg_addr_i),
    .reg_rdata_o   (reg_rdata_o),
    .regs_ready_o  (regs_ready_o),
    .sw_rst_busy_o (sw_rst_busy_o),
    .aneg_en_o     (aneg_en_o),
    .speed_sel_o   (speed_sel_o),
    .duplex_full_o (duplex_full_o),
    .pwr_down_o    (pwr_down_o),
    .shadow        (shadow)
);

// File: tb/phy_rst_strap_ctl_tb_top.sv
module phy_rst_strap_ctl_tb_top;

    localparam int unsigned AW  = 5;
    localparam int unsigned BLK = 20;
    localparam int unsigned SWR = 8;

    logic          clk = 1'b0;
    logic          hw_rst_n = 1'b0;
    logic          s_aneg = 1'b0, s_speed = 1'b0, s_dpx = 1'b0;
    logic          wr_en = 1'b0, rd_en = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [15:0]   wdata = '0;
    logic [15:0]   rdata;
    logic          ready, busy, aneg, speed, dpx, pdn;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    phy_rst_strap_ctl #(.ADDR_W(AW), .BLACKOUT_CYC(BLK), .SWRST_CYC(SWR)) dut_i (
        .clk(clk), .hw_rst_n(hw_rst_n),
        .strap_aneg_i(s_aneg), .strap_speed_i(s_speed), .strap_duplex_i(s_dpx),
        .reg_wr_en_i(wr_en), .reg_rd_en_i(rd_en), .reg_addr_i(addr),
        .reg_wdata_i(wdata), .reg_rdata_o(rdata), .regs_ready_o(ready),
        .sw_rst_busy_o(busy), .aneg_en_o(aneg), .speed_sel_o(speed),
        .duplex_full_o(dpx), .pwr_down_o(pdn)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_write(input logic [AW-1:0] a, input logic [15:0] d);
        addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic do_read(input logic [AW-1:0] a, output logic [15:0] d);
        addr = a; rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
        d = rdata;
    endtask

    // hold reset with the given straps, release and flip the pins in the release cycle
    task automatic hw_reset(input logic a, input logic s, input logic d);
        hw_rst_n = 1'b0;
        s_aneg = ~a; s_speed = ~s; s_dpx = ~d;
        repeat (3) @(negedge clk);
        s_aneg = a; s_speed = s; s_dpx = d;
        @(negedge clk);
        check("R1 live fields in reset", {aneg, speed, dpx, pdn}, {a, s, d, 1'b0});
        check("R3 ready low in reset", ready, 0);
        hw_rst_n = 1'b1;
        s_aneg = ~a; s_speed = ~s; s_dpx = ~d;
    endtask

    task automatic t_blackout();
        int n;
        logic [15:0] d;
        hw_reset(1'b1, 1'b1, 1'b0);
        addr = 0; wdata = 16'h0800; wr_en = 1'b1; rd_en = 1'b1;
        n = 0;
        for (int i = 0; i < 200; i++) begin
            @(negedge clk);
            n++;
            if (ready) break;
            check("R4 dark read zero", rdata, 0);
        end
        wr_en = 1'b0; rd_en = 1'b0;
        check("R3 blackout length", n, BLK + 1);
        do_read(0, d);
        check("R4 dark write ignored / R1 ctrl", d, 16'h3000);
        check("R2 live after pin flip", {aneg, speed, dpx, pdn}, 4'b1100);
        do_read(1, d);
        check("R2 strap readback", d, 16'h0003);
        do_read(7, d);
        check("R5 unmapped address", d, 0);
    endtask

    task automatic t_write();
        logic [15:0] d;
        do_write(0, 16'h0900);
        check("R6 fields after write", {aneg, speed, dpx, pdn}, 4'b0011);
        do_read(0, d);
        check("R6 readback", d, 16'h0900);
        do_write(0, 16'h3000);
        check("R6 second write", {aneg, speed, dpx, pdn}, 4'b1100);
        do_write(0, 16'h0800);
    endtask

    task automatic t_swreset();
        int k;
        logic [15:0] d;
        s_aneg = 1'b0; s_speed = 1'b0; s_dpx = 1'b1;
        do_write(0, 16'hB900);
        k = 0;
        check("R7 busy after start", busy, 1);
        check("R7 restored at start", {aneg, speed, dpx, pdn}, 4'b1100);
        do_read(0, d);
        k++;
        check("R8 read during reset", d, 16'hB000);
        do_write(0, 16'h0900);
        k++;
        check("R8 write ignored in reset", {aneg, speed, dpx, pdn}, 4'b1100);
        for (int i = 0; i < 100; i++) begin
            if (!busy) break;
            @(negedge clk);
            k++;
        end
        check("R7 busy length", k, SWR);
        do_read(0, d);
        check("R7 bit15 cleared / R9 no resample", d, 16'h3000);
        do_read(1, d);
        check("R9 shadow kept", d, 16'h0003);
    endtask

    task automatic t_abort();
        logic [15:0] d;
        do_write(0, 16'h8000);
        check("R10 busy before abort", busy, 1);
        hw_rst_n = 1'b0;
        s_aneg = 1'b0; s_speed = 1'b0; s_dpx = 1'b1;
        @(negedge clk);
        check("R10 busy cleared", busy, 0);
        check("R10 ready cleared", ready, 0);
        check("R1 new straps live", {aneg, speed, dpx, pdn}, 4'b0010);
        hw_rst_n = 1'b1;
        repeat (BLK + 1) @(negedge clk);
        check("R3 ready after second blackout", ready, 1);
        do_read(1, d);
        check("R1 new strap readback", d, 16'h0004);
        do_read(0, d);
        check("R5 control layout", d, 16'h0100);
    endtask

    initial begin
        @(negedge clk);
        check("R3 reset state ready", ready, 0);
        check("R5 reset rdata", rdata, 0);
        t_blackout();
        t_write();
        t_swreset();
        t_abort();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule